// File: doc/BRIEF.md
# Flag-Producing Shift and Rotate Unit

This block moves a data word left or right by a variable count in one pass and returns the new word together with the status flags a legacy integer datapath expects: carry, overflow, zero, sign and parity. It supports seven operations: plain rotate left and right, rotate left and right through the carry bit, logical shift left and right, and arithmetic shift right. Each flag comes with a write strobe. Flags that an operation does not touch keep their old value in the register that holds them, and the block leaves the register file and any memory read-modify-write to the logic around it.

The count comes from one of three places: an immediate byte, the constant one, or the low byte of a count register. The effective count depends on the operation. Plain rotates keep 4 bits of it. All other operations keep 5 bits, and the rotates through carry then reduce that value modulo 17. When the effective count is zero, nothing is written, neither the word nor any flag. A parameter adds a pipeline register at the output, which gives one cycle of latency.

Top module: `shrot_unit`

## Requirements
- R1: `cnt_sel` picks the raw count: 0 takes `imm_cnt`, 1 takes the constant 1, and 2 or 3 take `reg_cnt`.
- R2: Plain rotates (`op_sel` 0 = rotate left, 1 = rotate right) use only raw count bits [3:0], so a raw count of 16 has no effect.
- R3: The other operations (`op_sel` 2 = rotate left through carry, 3 = rotate right through carry, 4 = logical shift left, 5 = logical shift right, 6 = arithmetic shift right) use raw count bits [4:0]. The two rotates through carry then reduce that value modulo 17.
- R4: When the effective count is zero, or when `op_sel` is 7 (reserved), every write strobe is low and `result` equals `operand`.
- R5: After a plain rotate left, carry equals result bit 0. After a plain rotate right, carry equals result bit 15. Plain rotates write only carry and overflow.
- R6: A rotate through carry turns the 17-bit value {carry_in, operand} by the effective count. The carry out is operand bit (16 − n) for a left turn and operand bit (n − 1) for a right turn.
- R7: Overflow is written only when the effective count is 1. For any rotate, it is set when bit 15 of the result differs from bit 15 of the operand.
- R8: Logical shifts fill with zeros, and carry is the last bit shifted out. A count of 17 or more gives a zero result and a clear carry. On a count of 1, overflow is result[15] XOR carry for the left shift and operand[15] for the right shift.
- R9: Arithmetic shift right fills with the sign bit. With a count of 16 or more, the result is all sign bits and carry equals the sign. Below 16, carry is operand bit (n − 1). On a count of 1, overflow is cleared.
- R10: The three shifts also write zero (result == 0), sign (result[15]) and parity (set when result[7:0] holds an even number of ones).
- R11: Each flag output reads 0 whenever its strobe is low.
- R12: With `REG_OUT` = 1, outputs appear one clock after `in_valid`, qualified by `out_valid`. All outputs are clear while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 3 | Operation code (see R2, R3, R4) |
| cnt_sel | input | 2 | Count source select |
| imm_cnt | input | 8 | Immediate count byte |
| reg_cnt | input | 8 | Count register low byte |
| operand | input | 16 | Data word |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Outputs hold a result |
| result | output | 16 | Shifted or rotated word |
| res_we | output | 1 | Write strobe for the result |
| cf | output | 1 | Carry |
| cf_we | output | 1 | Carry write strobe |
| of | output | 1 | Overflow |
| of_we | output | 1 | Overflow write strobe |
| zf | output | 1 | Zero |
| zf_we | output | 1 | Zero write strobe |
| sf | output | 1 | Sign |
| sf_we | output | 1 | Sign write strobe |
| pf | output | 1 | Parity |
| pf_we | output | 1 | Parity write strobe |

## Verification
The bench builds the unit with the default 16-bit width and 5-bit count field, and with `REG_OUT` = 1. The registered variant exercises the one-cycle latency, the `out_valid` qualification and the idle bubbles, none of which exist in the combinational variant. Because the count field is 5 bits wide, the bench can sweep every raw count from 0 to 31 against each operation, which covers the masking to 4 bits, the modulo-17 reduction and the fills beyond 16 places.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
   typedef enum logic [2:0] {
      OP_ROL  = 3'd0,
      OP_ROR  = 3'd1,
      OP_RCL  = 3'd2,
      OP_RCR  = 3'd3,
      OP_SHL  = 3'd4,
      OP_SHR  = 3'd5,
      OP_SAR  = 3'd6,
      OP_NONE = 3'd7
   } shrot_op_e;

   typedef enum logic [1:0] {
      CS_IMM  = 2'd0,
      CS_ONE  = 2'd1,
      CS_REG  = 2'd2,
      CS_REG2 = 2'd3
   } shrot_cnt_src_e;

   function automatic logic is_plain_rot(input shrot_op_e op);
      return (op == OP_ROL) || (op == OP_ROR);
   endfunction

   function automatic logic is_shift(input shrot_op_e op);
      return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
   endfunction
endpackage

// File: rtl/shrot_count.sv
module shrot_count
   import shrot_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int IN_BITS  = 8,
   parameter int CNT_BITS = 5
) (
   input  shrot_op_e            op,
   input  shrot_cnt_src_e       src,
   input  logic [IN_BITS-1:0]   imm_cnt,
   input  logic [IN_BITS-1:0]   reg_cnt,
   output logic [CNT_BITS-1:0]  eff_cnt
);
   localparam int ROT_BITS = $clog2(WIDTH);
   localparam logic [CNT_BITS:0] MODV = (CNT_BITS+1)'(WIDTH + 1);

   logic [IN_BITS-1:0]  raw;
   logic [CNT_BITS-1:0] rot_cnt;
   logic [CNT_BITS-1:0] wide_cnt;
   logic [CNT_BITS:0]   rc_full;

   always_comb begin
      unique case (src)
         CS_IMM:  raw = imm_cnt;
         CS_ONE:  raw = IN_BITS'(1);
         default: raw = reg_cnt;
      endcase
   end

   assign rot_cnt  = CNT_BITS'(raw[ROT_BITS-1:0]);
   assign wide_cnt = raw[CNT_BITS-1:0];
   assign rc_full  = {1'b0, wide_cnt} % MODV;

   always_comb begin
      if (is_plain_rot(op))                    eff_cnt = rot_cnt;
      else if (op == OP_RCL || op == OP_RCR)   eff_cnt = rc_full[CNT_BITS-1:0];
      else if (op == OP_NONE)                  eff_cnt = '0;
      else                                     eff_cnt = wide_cnt;
   end
endmodule

// File: rtl/shrot_datapath.sv
module shrot_datapath
   import shrot_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int CNT_BITS = 5
) (
   input  shrot_op_e            op,
   input  logic [CNT_BITS-1:0]  cnt,
   input  logic [WIDTH-1:0]     a,
   input  logic                 cin,
   output logic [WIDTH-1:0]     res,
   output logic                 cout
);
   localparam int DW = 2 * WIDTH;
   localparam int TW = 2 * (WIDTH + 1);
   localparam logic [CNT_BITS-1:0] CW_MAX = CNT_BITS'(WIDTH);

   logic [DW-1:0]    rot_l, rot_r, shl_v, shr_v;
   logic [TW-1:0]    rc_l, rc_r;
   logic [WIDTH:0]   rcl_w, rcr_w;
   logic [3*WIDTH-1:0] sar_v;
   logic [CNT_BITS-1:0] sar_cnt;
   logic sgn;

   assign sgn     = a[WIDTH-1];
   assign sar_cnt = (cnt >= CW_MAX) ? CW_MAX : cnt;

   assign rot_l = {a, a} << cnt;
   assign rot_r = {a, a} >> cnt;
   assign rc_l  = {cin, a, cin, a} << cnt;
   assign rc_r  = {cin, a, cin, a} >> cnt;
   assign rcl_w = rc_l[TW-1:WIDTH+1];
   assign rcr_w = rc_r[WIDTH:0];
   assign shl_v = DW'(a) << cnt;
   assign shr_v = {a, {WIDTH{1'b0}}} >> cnt;
   assign sar_v = {{WIDTH{sgn}}, a, {WIDTH{1'b0}}} >> sar_cnt;

   always_comb begin
      res  = a;
      cout = 1'b0;
      unique case (op)
         OP_ROL: begin res = rot_l[DW-1:WIDTH]; cout = rot_l[WIDTH];   end
         OP_ROR: begin res = rot_r[WIDTH-1:0];  cout = rot_r[WIDTH-1]; end
         OP_RCL: begin res = rcl_w[WIDTH-1:0];  cout = rcl_w[WIDTH];   end
         OP_RCR: begin res = rcr_w[WIDTH-1:0];  cout = rcr_w[WIDTH];   end
         OP_SHL: begin res = shl_v[WIDTH-1:0];  cout = shl_v[WIDTH];   end
         OP_SHR: begin res = shr_v[DW-1:WIDTH]; cout = shr_v[WIDTH-1]; end
         OP_SAR: begin res = sar_v[DW-1:WIDTH]; cout = sar_v[WIDTH-1]; end
         default: begin res = a; cout = 1'b0; end
      endcase
   end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
   import shrot_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int CNT_BITS = 5,
   parameter int PAR_BITS = 8
) (
   input  logic                 valid,
   input  shrot_op_e            op,
   input  logic [CNT_BITS-1:0]  cnt,
   input  logic [WIDTH-1:0]     a,
   input  logic [WIDTH-1:0]     res,
   input  logic                 cout,
   output logic                 res_we,
   output logic                 cf, cf_we,
   output logic                 of, of_we,
   output logic                 zf, zf_we,
   output logic                 sf, sf_we,
   output logic                 pf, pf_we
);
   logic one_step;
   logic of_val;

   assign res_we   = valid && (op != OP_NONE) && (cnt != '0);
   assign one_step = (cnt == CNT_BITS'(1));

   always_comb begin
      unique case (op)
         OP_SHL:  of_val = res[WIDTH-1] ^ cout;
         OP_SHR:  of_val = a[WIDTH-1];
         OP_SAR:  of_val = 1'b0;
         default: of_val = a[WIDTH-1] ^ res[WIDTH-1];
      endcase
   end

   assign cf_we = res_we;
   assign of_we = res_we && one_step;
   assign zf_we = res_we && is_shift(op);
   assign sf_we = zf_we;
   assign pf_we = zf_we;

   assign cf = cf_we & cout;
   assign of = of_we & of_val;
   assign zf = zf_we & (res == '0);
   assign sf = sf_we & res[WIDTH-1];
   assign pf = pf_we & ~(^res[PAR_BITS-1:0]);
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
   import shrot_pkg::*;
#(
   parameter int WIDTH    = 16,
   parameter int IN_BITS  = 8,
   parameter int CNT_BITS = 5,
   parameter int PAR_BITS = 8,
   parameter bit REG_OUT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [2:0]         op_sel,
   input  logic [1:0]         cnt_sel,
   input  logic [IN_BITS-1:0] imm_cnt,
   input  logic [IN_BITS-1:0] reg_cnt,
   input  logic [WIDTH-1:0]   operand,
   input  logic               carry_in,
   output logic               out_valid,
   output logic [WIDTH-1:0]   result,
   output logic               res_we,
   output logic               cf,
   output logic               cf_we,
   output logic               of,
   output logic               of_we,
   output logic               zf,
   output logic               zf_we,
   output logic               sf,
   output logic               sf_we,
   output logic               pf,
   output logic               pf_we
);
   localparam int ROT_BITS = $clog2(WIDTH);
   localparam int BW       = WIDTH + 12;

   if ((1 << ROT_BITS) != WIDTH) begin : g_bad_width
      $error("shrot_unit: WIDTH must be a power of two");
   end
   if (ROT_BITS > CNT_BITS || (1 << CNT_BITS) > 2 * WIDTH) begin : g_bad_cnt
      $error("shrot_unit: CNT_BITS must cover log2(WIDTH) and stay within 2*WIDTH");
   end
   if (CNT_BITS > IN_BITS || PAR_BITS > WIDTH) begin : g_bad_fields
      $error("shrot_unit: count or parity field too wide");
   end

   shrot_op_e           op;
   shrot_cnt_src_e      src;
   logic [CNT_BITS-1:0] eff_cnt;
   logic [WIDTH-1:0]    c_res;
   logic                c_cout;
   logic                c_res_we, c_cf, c_cf_we, c_of, c_of_we;
   logic                c_zf, c_zf_we, c_sf, c_sf_we, c_pf, c_pf_we;
   logic [BW-1:0]       bundle, bundle_q;

   assign op  = shrot_op_e'(op_sel);
   assign src = shrot_cnt_src_e'(cnt_sel);

   shrot_count #(.WIDTH(WIDTH), .IN_BITS(IN_BITS), .CNT_BITS(CNT_BITS)) u_count (
      .op(op), .src(src), .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .eff_cnt(eff_cnt)
   );

   shrot_datapath #(.WIDTH(WIDTH), .CNT_BITS(CNT_BITS)) u_dp (
      .op(op), .cnt(eff_cnt), .a(operand), .cin(carry_in), .res(c_res), .cout(c_cout)
   );

   shrot_flags #(.WIDTH(WIDTH), .CNT_BITS(CNT_BITS), .PAR_BITS(PAR_BITS)) u_flags (
      .valid(in_valid), .op(op), .cnt(eff_cnt), .a(operand), .res(c_res), .cout(c_cout),
      .res_we(c_res_we), .cf(c_cf), .cf_we(c_cf_we), .of(c_of), .of_we(c_of_we),
      .zf(c_zf), .zf_we(c_zf_we), .sf(c_sf), .sf_we(c_sf_we), .pf(c_pf), .pf_we(c_pf_we)
   );

   assign bundle = {in_valid, c_res, c_res_we, c_cf, c_cf_we, c_of, c_of_we,
                    c_zf, c_zf_we, c_sf, c_sf_we, c_pf, c_pf_we};

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bundle_q <= '0;
         else        bundle_q <= bundle;
      end
   end else begin : g_comb
      assign bundle_q = bundle;
   end

   assign {out_valid, result, res_we, cf, cf_we, of, of_we,
           zf, zf_we, sf, sf_we, pf, pf_we} = bundle_q;
endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
   parameter int WIDTH    = 16,
   parameter int PAR_BITS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             out_valid,
   input logic [WIDTH-1:0] result,
   input logic             res_we,
   input logic             cf, cf_we,
   input logic             of, of_we,
   input logic             zf, zf_we,
   input logic             sf, sf_we,
   input logic             pf, pf_we
);
   assert_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !res_we |-> !(cf_we || of_we || zf_we || sf_we || pf_we));

   assert_of_only_with_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      of_we |-> (res_we && cf_we));

   assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      zf_we |-> (zf == (result == '0)));

   assert_sign_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sf_we |-> (sf == result[WIDTH-1]));

   assert_parity_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pf_we |-> (pf == ~(^result[PAR_BITS-1:0])));

   assert_shift_flag_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
      zf_we |-> (sf_we && pf_we && cf_we));

   assert_silent_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!cf_we |-> !cf) and (!of_we |-> !of) and (!zf_we |-> !zf)
      and (!sf_we |-> !sf) and (!pf_we |-> !pf));

   assert_no_write_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !res_we);
endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) u_chk (.*);

// File: tb/tb_shrot_unit.sv
module tb_shrot_unit;
   localparam int W  = 16;
   localparam int EW = W + 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [2:0] op_sel = '0;
   logic [1:0] cnt_sel = '0;
   logic [7:0] imm_cnt = '0, reg_cnt = '0;
   logic [W-1:0] operand = '0;
   logic carry_in = 1'b0;
   logic out_valid, res_we, cf, cf_we, of, of_we, zf, zf_we, sf, sf_we, pf, pf_we;
   logic [W-1:0] result;

   int n_vec = 0;
   int n_bad = 0;
   logic [EW-1:0] exp_q[$];
   string tag_q[$];

   always #10 clk = ~clk;

   shrot_unit #(.WIDTH(W), .REG_OUT(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .cnt_sel(cnt_sel),
      .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .operand(operand), .carry_in(carry_in),
      .out_valid(out_valid), .result(result), .res_we(res_we), .cf(cf), .cf_we(cf_we),
      .of(of), .of_we(of_we), .zf(zf), .zf_we(zf_we), .sf(sf), .sf_we(sf_we),
      .pf(pf), .pf_we(pf_we)
   );

   // Reference model: single-bit steps, repeated n times.
   function automatic logic [EW-1:0] model(input logic [2:0] op, input logic [1:0] sel,
                                           input logic [7:0] imm, input logic [7:0] rg,
                                           input logic [W-1:0] a, input logic cin);
      logic [7:0] raw;
      int n, ones;
      logic [W-1:0] r;
      logic k, b, o, wr, shf;
      raw = (sel == 2'd0) ? imm : (sel == 2'd1) ? 8'd1 : rg;
      if (op <= 3'd1)      n = int'(raw & 8'h0F);
      else if (op <= 3'd3) n = int'(raw & 8'h1F) % 17;
      else                 n = int'(raw & 8'h1F);
      if (op == 3'd7) n = 0;
      r = a; k = cin;
      for (int i = 0; i < n; i++) begin
         case (op)
            3'd0: begin b = r[W-1]; r = {r[W-2:0], b}; end
            3'd1: begin b = r[0];   r = {b, r[W-1:1]}; end
            3'd2: begin b = r[W-1]; r = {r[W-2:0], k}; k = b; end
            3'd3: begin b = r[0];   r = {k, r[W-1:1]}; k = b; end
            3'd4: begin k = r[W-1]; r = {r[W-2:0], 1'b0}; end
            3'd5: begin k = r[0];   r = {1'b0, r[W-1:1]}; end
            default: begin k = r[0]; r = {r[W-1], r[W-1:1]}; end
         endcase
      end
      if (op == 3'd0) k = r[0];
      if (op == 3'd1) k = r[W-1];
      wr  = (n != 0);
      shf = wr && (op >= 3'd4);
      case (op)
         3'd4:    o = r[W-1] ^ k;
         3'd5:    o = a[W-1];
         3'd6:    o = 1'b0;
         default: o = a[W-1] ^ r[W-1];
      endcase
      ones = 0;
      for (int i = 0; i < 8; i++) ones += int'(r[i]);
      if (!wr) begin r = a; k = 1'b0; end
      return {r, wr, wr & k, wr, (wr && n == 1) & o, wr && n == 1,
              shf & (r == '0), shf, shf & r[W-1], shf, shf & (ones % 2 == 0), shf};
   endfunction

   function automatic string tag_of(input logic [2:0] op, input logic [EW-1:0] e);
      if (!e[10]) return "R4";
      if (op <= 3'd1) return "R5";
      if (op <= 3'd3) return "R6";
      if (op <= 3'd5) return "R8";
      return "R9";
   endfunction

   task automatic drive(input logic [2:0] op, input logic [1:0] sel, input logic [7:0] imm,
                        input logic [7:0] rg, input logic [W-1:0] a, input logic cin,
                        input string tag);
      logic [EW-1:0] e;
      in_valid = 1'b1; op_sel = op; cnt_sel = sel; imm_cnt = imm; reg_cnt = rg;
      operand = a; carry_in = cin;
      e = model(op, sel, imm, rg, a, cin);
      exp_q.push_back(e);
      tag_q.push_back((tag == "") ? tag_of(op, e) : tag);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Monitor: compare each valid output against the oldest expected item.
   always @(posedge clk) begin
      logic [EW-1:0] act, e;
      string t;
      #2;
      if (rst_n && out_valid) begin
         act = {result, res_we, cf, cf_we, of, of_we, zf, zf_we, sf, sf_we, pf, pf_we};
         n_vec++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R12 unexpected output: actual=%h expected=none", act);
         end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (act !== e) begin
               n_bad++;
               $display("FAIL %s op=%0d: actual=%h expected=%h", t, op_sel, act, e);
            end
         end
      end
   end

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL R12 watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12: all outputs clear under reset
      n_vec++;
      if ({out_valid, result, res_we, cf_we, of_we, zf_we} !== '0) begin
         n_bad++;
         $display("FAIL R12 reset: actual=%h expected=0", {out_valid, result, res_we});
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2: rotate counts use 4 bits; 16 acts as zero
      drive(3'd0, 2'd2, 8'h00, 8'h10, 16'h8001, 1'b0, "R2");
      drive(3'd1, 2'd2, 8'h00, 8'h13, 16'h1234, 1'b1, "R2");
      // R3: 5-bit mask and modulo 17
      drive(3'd2, 2'd2, 8'h00, 8'h11, 16'hA5A5, 1'b1, "R3");
      drive(3'd3, 2'd2, 8'h00, 8'h12, 16'h0001, 1'b0, "R3");
      drive(3'd4, 2'd2, 8'h00, 8'h25, 16'h0F0F, 1'b0, "R3");
      // R1: count sources
      drive(3'd5, 2'd0, 8'hE1, 8'h07, 16'h8000, 1'b0, "R1");
      drive(3'd5, 2'd1, 8'h00, 8'h00, 16'h8000, 1'b0, "R1");
      drive(3'd4, 2'd3, 8'h09, 8'h03, 16'h00FF, 1'b0, "R1");
      // R7: overflow on count one
      drive(3'd4, 2'd1, 8'h00, 8'h00, 16'h4000, 1'b0, "R7");
      drive(3'd0, 2'd1, 8'h00, 8'h00, 16'h4000, 1'b0, "R7");
      // R9: arithmetic fill beyond width
      drive(3'd6, 2'd0, 8'h14, 8'h00, 16'h8000, 1'b0, "R9");
      // R10: zero, sign and parity
      drive(3'd5, 2'd0, 8'h08, 8'h00, 16'h0100, 1'b0, "R10");
      drive(3'd4, 2'd1, 8'h00, 8'h00, 16'h8000, 1'b0, "R10");
      // R4: reserved op never writes
      drive(3'd7, 2'd0, 8'h05, 8'h00, 16'hBEEF, 1'b1, "R4");
      // R11: flags silent when not written (plain rotate writes no zero/sign/parity)
      drive(3'd0, 2'd0, 8'h04, 8'h00, 16'h0000, 1'b1, "R11");

      // R12: an idle cycle produces no valid output
      @(negedge clk);
      n_vec++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R12 bubble: actual=%b expected=0", out_valid);
      end

      // Sweep of every operation and raw count with random data
      for (int op = 0; op < 8; op++) begin
         for (int c = 0; c < 32; c++) begin
            for (int rep = 0; rep < 2; rep++) begin
               logic [7:0] hi;
               hi = {3'($urandom), 5'(c)};
               drive(3'(op), 2'd2, 8'($urandom), hi, 16'($urandom), 1'($urandom), "");
               drive(3'(op), 2'd0, hi, 8'($urandom), 16'($urandom), 1'($urandom), "");
            end
         end
      end

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R12 missing outputs: actual=%0d expected=0", exp_q.size());
      end
      finish_run();
   end
endmodule